// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port input or port output access, issued by code running at some current privilege level, may go ahead. A request carries the current privilege level, the I/O privilege level, the 16-bit port number, the access width, the 16-bit offset of the permission bitmap inside the task segment, and the segment limit. When the current level is at least as privileged as the I/O level, every port is open. The block then answers at once and does not touch memory.

Otherwise the block works out which bitmap bytes cover the ports touched by the access. It checks those byte addresses against the segment limit and fetches them through a synchronous read port with a fixed latency of one cycle. It tests the bits of the touched ports and returns a one-cycle done pulse with either allow or fault. A set bit denies its port. A clear bit permits it.

Only one check is in flight at a time. The caller holds a request until the block shows it is idle, and then waits for done.

Top module: `port_access_gate`

## Requirements
- R1: If req_cpl <= req_iopl (unsigned 2-bit compare), the access is allowed whatever the bitmap and limit are, no memory read is issued, and done rises two clock edges after the accepting edge.
- R2: If req_cpl > req_iopl, the bitmap decides: port p is covered by the byte at address bitmap_ofs + (p >> 3), at bit position p[2:0], where bit 0 is the least significant bit of the byte.
- R3: A covering bit of 0 permits its port and a covering bit of 1 denies it. Any denied port makes the whole access a fault.
- R4: The result is a done pulse of exactly one cycle. While done is high, exactly one of allow and fault is high. While done is low, both are low.
- R5: req_width 00 touches 1 port, 01 touches 2 ports, and 10 or 11 touch 4 ports. The touched ports are p, p+1, ..., and every covering bit must be clear. Bit index p+k is taken as a 17-bit sum without wrapping, so port 0xFFFF reaches into the byte after offset + 0x1FFF.
- R6: When the covering bits lie in one byte, one read is issued and done rises three edges after acceptance. When they cross a byte boundary, the lower address is read first and the next address in the following cycle, and done rises four edges after acceptance.
- R7: If any needed byte address is greater than seg_limit, the access is a fault. No read is issued, and done rises two edges after acceptance.
- R8: req_ready is high only when the block is idle. A request is taken at a clock edge where req_valid and req_ready are both high, and all request inputs are sampled only at that edge. mem_rd_data is taken one cycle after mem_rd_en.
- R9: After reset, req_ready is high and done, allow, fault and mem_rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| req_port | input | 16 | First port number of the access |
| req_width | input | 2 | Access width code (00 one port, 01 two ports, 1x four ports) |
| bitmap_ofs | input | 16 | Byte offset of the permission bitmap in the task segment |
| seg_limit | input | 17 | Highest legal byte address of the task segment |
| mem_rd_en | output | 1 | Bitmap byte read strobe |
| mem_rd_addr | output | 17 | Bitmap byte read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle result pulse |
| allow | output | 1 | Access permitted, valid with done |
| fault | output | 1 | Access denied (general-protection fault), valid with done |

## Verification
Privileged requests are issued against an all-ones bitmap and a zero limit. This shows that the level compare alone grants access and that no read is issued. Unprivileged requests run against all-zero, all-one and single-set-bit bitmaps at chosen ports and widths. These tell apart the bit position, the byte address and the width masks, including the 2-port and 4-port spans that cross a byte and the 4-port span that starts at port 0xFFFF. Limits placed just below, at and above the first and second bitmap bytes separate the limit fault from a bitmap fault. Random requests with hashed bitmaps then check the verdict, the read count, the read order and the latency against a model written from the requirements, with the request inputs scrambled after acceptance.

// File: rtl/pag_pkg.sv
// Package: shared widths, encodings and helpers for the port access gate.
// Assumes default widths of a 2-bit privilege level, a 16-bit port and a 16-bit offset.
package pag_pkg;
    localparam int PAG_PL_W   = 2;
    localparam int PAG_PORT_W = 16;
    localparam int PAG_OFS_W  = 16;
    localparam int PAG_BYTE_W = 8;
    // Byte addresses need one bit above the wider of offset and byte index.
    localparam int PAG_ADDR_W =
        ((PAG_OFS_W > PAG_PORT_W - 3) ? PAG_OFS_W : PAG_PORT_W - 3) + 1;

    // Access width codes.
    typedef enum logic [1:0] {
        W_ONE   = 2'b00,
        W_TWO   = 2'b01,
        W_FOUR  = 2'b10,
        W_FOUR2 = 2'b11
    } acc_width_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_LO     = 2'd2,
        ST_HI     = 2'd3
    } pag_state_e;

    // Number of touched ports minus one for a width code.
    function automatic logic [2:0] span_minus_one(input logic [1:0] code);
        case (code)
            W_ONE:   return 3'd0;
            W_TWO:   return 3'd1;
            default: return 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/pag_priv_cmp.sv
// Privilege compare: grants blanket port access when the current level is
// numerically no greater than the I/O level. Pure combinational.
module pag_priv_cmp #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            blanket
);
    // Unsigned compare of the two levels.
    always_comb blanket = (cpl <= iopl);
endmodule

// File: rtl/pag_span_gen.sv
// Span generator: from port, width and bitmap offset forms the first and
// second bitmap byte addresses, the bit masks inside each byte, whether the
// span crosses a byte, and whether a needed byte lies above the limit.
// Assumes at most 4 touched ports, so at most two bytes are needed.
module pag_span_gen #(
    parameter int PORT_W = 16,
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 17,
    parameter int BYTE_W = 8
) (
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        width,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              crosses,
    output logic [BYTE_W-1:0] mask_lo,
    output logic [BYTE_W-1:0] mask_hi,
    output logic              out_of_range
);
    import pag_pkg::*;

    localparam int BIT_W = $clog2(BYTE_W);
    localparam int POS_W = BIT_W + 1;

    logic [POS_W-1:0] first_pos;
    logic [POS_W-1:0] last_pos;

    // Bit positions of the first and last touched port, relative to the low byte.
    always_comb begin
        first_pos = {1'b0, port[BIT_W-1:0]};
        last_pos  = first_pos + POS_W'(span_minus_one(width));
        crosses   = last_pos[BIT_W];
    end

    // One mask bit per bitmap bit, for the low and the high byte.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        always_comb begin
            mask_lo[i] = (POS_W'(i) >= first_pos) && (POS_W'(i) <= last_pos);
            mask_hi[i] = (POS_W'(i + BYTE_W) <= last_pos);
        end
    end

    // Byte addresses and the limit test.
    always_comb begin
        addr_lo      = ADDR_W'(ofs) + ADDR_W'(port[PORT_W-1:BIT_W]);
        addr_hi      = addr_lo + ADDR_W'(1);
        out_of_range = (addr_lo > limit) || (crosses && (addr_hi > limit));
    end
endmodule

// File: rtl/pag_byte_test.sv
// Byte test: reports whether any masked bit of a fetched bitmap byte is set.
module pag_byte_test #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] mask,
    output logic              denied
);
    // A set bit under the mask denies the access.
    always_comb denied = |(data & mask);
endmodule

// File: rtl/port_access_gate.sv
// Port access gate: takes one permission request at a time, grants it
// outright on the privilege compare, or else fetches one or two bitmap bytes
// (read latency one cycle) and returns allow or fault on a done pulse.
// Assumes the memory answers every strobe exactly one cycle later.
module port_access_gate
    import pag_pkg::*;
#(
    parameter int PL_W   = PAG_PL_W,
    parameter int PORT_W = PAG_PORT_W,
    parameter int OFS_W  = PAG_OFS_W,
    parameter int BYTE_W = PAG_BYTE_W,
    localparam int ADDR_W = ((OFS_W > PORT_W - 3) ? OFS_W : PORT_W - 3) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PL_W-1:0]   req_cpl,
    input  logic [PL_W-1:0]   req_iopl,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_width,
    input  logic [OFS_W-1:0]  bitmap_ofs,
    input  logic [ADDR_W-1:0] seg_limit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              done,
    output logic              allow,
    output logic              fault
);
    pag_state_e        state, state_d;
    logic [PL_W-1:0]   l_cpl, l_iopl;
    logic [PORT_W-1:0] l_port;
    logic [1:0]        l_width;
    logic [OFS_W-1:0]  l_ofs;
    logic [ADDR_W-1:0] l_limit;
    logic              deny_lo_q, deny_lo_d;
    logic              done_q, allow_q, fault_q;

    logic              blanket;
    logic [ADDR_W-1:0] addr_lo, addr_hi;
    logic              crosses, out_of_range;
    logic [BYTE_W-1:0] mask_lo, mask_hi;
    logic              hit_lo, hit_hi;
    logic              finish, verdict;

    pag_priv_cmp #(.PL_W(PL_W)) u_priv (
        .cpl     (l_cpl),
        .iopl    (l_iopl),
        .blanket (blanket)
    );

    pag_span_gen #(
        .PORT_W (PORT_W),
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_span (
        .port         (l_port),
        .width        (l_width),
        .ofs          (l_ofs),
        .limit        (l_limit),
        .addr_lo      (addr_lo),
        .addr_hi      (addr_hi),
        .crosses      (crosses),
        .mask_lo      (mask_lo),
        .mask_hi      (mask_hi),
        .out_of_range (out_of_range)
    );

    pag_byte_test #(.BYTE_W(BYTE_W)) u_test_lo (
        .data   (mem_rd_data),
        .mask   (mask_lo),
        .denied (hit_lo)
    );

    pag_byte_test #(.BYTE_W(BYTE_W)) u_test_hi (
        .data   (mem_rd_data),
        .mask   (mask_hi),
        .denied (hit_hi)
    );

    // Next state, read strobe and verdict for the current state.
    always_comb begin
        state_d     = state;
        mem_rd_en   = 1'b0;
        mem_rd_addr = addr_lo;
        deny_lo_d   = deny_lo_q;
        finish      = 1'b0;
        verdict     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (blanket) begin
                    finish  = 1'b1;
                    verdict = 1'b1;
                end else if (out_of_range) begin
                    finish  = 1'b1;
                    verdict = 1'b0;
                end else begin
                    mem_rd_en = 1'b1;
                    state_d   = ST_LO;
                end
            end
            ST_LO: begin
                if (crosses) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = addr_hi;
                    deny_lo_d   = hit_lo;
                    state_d     = ST_HI;
                end else begin
                    finish  = 1'b1;
                    verdict = !hit_lo;
                end
            end
            default: begin
                finish  = 1'b1;
                verdict = !(deny_lo_q || hit_hi);
            end
        endcase
        if (finish) state_d = ST_IDLE;
    end

    // State, result registers and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            deny_lo_q <= 1'b0;
            done_q    <= 1'b0;
            allow_q   <= 1'b0;
            fault_q   <= 1'b0;
            l_cpl     <= '0;
            l_iopl    <= '0;
            l_port    <= '0;
            l_width   <= '0;
            l_ofs     <= '0;
            l_limit   <= '0;
        end else begin
            state     <= state_d;
            deny_lo_q <= deny_lo_d;
            done_q    <= finish;
            allow_q   <= finish && verdict;
            fault_q   <= finish && !verdict;
            if (state == ST_IDLE && req_valid) begin
                l_cpl   <= req_cpl;
                l_iopl  <= req_iopl;
                l_port  <= req_port;
                l_width <= req_width;
                l_ofs   <= bitmap_ofs;
                l_limit <= seg_limit;
            end
        end
    end

    // Port drive from state and result registers.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = done_q;
        allow     = allow_q;
        fault     = fault_q;
    end
endmodule

// File: rtl/pag_sva.sv
// Checker for the port access gate, observing its ports only.
module pag_sva #(
    parameter int PL_W   = 2,
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PL_W-1:0]   req_cpl,
    input logic [PL_W-1:0]   req_iopl,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              done,
    input logic              allow,
    input logic              fault
);
    // R1: privileged request is granted two edges later with no read on the way.
    assert_priv_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_cpl <= req_iopl)) |-> ##2 (done && allow));
    assert_priv_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_cpl <= req_iopl)) |=> !mem_rd_en);
    // R4: single-cycle done carrying exactly one verdict.
    assert_verdict_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow != fault));
    assert_verdict_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!allow && !fault));
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: back-to-back reads go to consecutive addresses.
    assert_read_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));
    // R8: accepted request makes the block busy; done returns it to idle.
    assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind port_access_gate pag_sva #(.PL_W(PL_W), .ADDR_W(ADDR_W)) u_pag_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cpl     (req_cpl),
    .req_iopl    (req_iopl),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .done        (done),
    .allow       (allow),
    .fault       (fault)
);

// File: tb/test_port_access_gate.sv
// Bench for port_access_gate: directed corners plus seeded random requests.
module test_port_access_gate;
    import pag_pkg::*;
    localparam int AW = PAG_ADDR_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_cpl = '0, req_iopl = '0, req_width = '0;
    logic [15:0]   req_port = '0, bitmap_ofs = '0;
    logic [AW-1:0] seg_limit = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data = '0;
    logic          done, allow, fault;

    int checks = 0;
    int failures = 0;

    int            pat_mode = 0;
    logic [31:0]   pat_key = '0;
    logic [AW-1:0] tgt_addr = '0;
    int            tgt_bit = 0;

    int            rd_total = 0;
    logic [AW-1:0] last_addr = '0, prev_addr = '0;

    always #5 clk = ~clk;

    port_access_gate i_port_access_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cpl(req_cpl), .req_iopl(req_iopl), .req_port(req_port),
        .req_width(req_width), .bitmap_ofs(bitmap_ofs), .seg_limit(seg_limit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .allow(allow), .fault(fault)
    );

    // Bitmap contents as a function of the byte address.
    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [31:0] h;
        h = (32'(a) * 32'h9E3779B1) ^ pat_key;
        case (pat_mode)
            0: return 8'h00;
            1: return 8'hFF;
            2: return h[23:16] & h[15:8];
            default: return (a == tgt_addr) ? 8'(1 << tgt_bit) : 8'h00;
        endcase
    endfunction

    // One-cycle synchronous read memory model with read logging.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem_byte(mem_rd_addr);
            rd_total    <= rd_total + 1;
            prev_addr   <= last_addr;
            last_addr   <= mem_rd_addr;
        end
    end

    function automatic int n_ports(input logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [AW-1:0] byte_addr(input logic [15:0] ofs, input logic [16:0] b);
        return AW'(ofs) + AW'(b >> 3);
    endfunction

    // Limit fault per R7: some needed byte above the limit.
    function automatic bit limit_bad(input logic [15:0] port, input logic [1:0] w,
                                     input logic [15:0] ofs, input logic [AW-1:0] lim);
        for (int k = 0; k < n_ports(w); k++)
            if (byte_addr(ofs, 17'(port) + 17'(k)) > lim) return 1'b1;
        return 1'b0;
    endfunction

    // Verdict per R1, R2, R3, R5, R7.
    function automatic bit exp_allow(input logic [1:0] cpl, input logic [1:0] iopl,
                                     input logic [15:0] port, input logic [1:0] w,
                                     input logic [15:0] ofs, input logic [AW-1:0] lim);
        logic [16:0] b;
        logic [7:0]  d;
        if (cpl <= iopl) return 1'b1;
        if (limit_bad(port, w, ofs, lim)) return 1'b0;
        for (int k = 0; k < n_ports(w); k++) begin
            b = 17'(port) + 17'(k);
            d = mem_byte(byte_addr(ofs, b));
            if (d[b[2:0]]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Read count per R1, R6, R7.
    function automatic int exp_reads(input logic [1:0] cpl, input logic [1:0] iopl,
                                     input logic [15:0] port, input logic [1:0] w,
                                     input logic [15:0] ofs, input logic [AW-1:0] lim);
        if (cpl <= iopl) return 0;
        if (limit_bad(port, w, ofs, lim)) return 0;
        return ((int'(port[2:0]) + n_ports(w) - 1) > 7) ? 2 : 1;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and check verdict, reads, order and latency.
    task automatic run_req(input string tag, input logic [1:0] cpl, input logic [1:0] iopl,
                           input logic [15:0] port, input logic [1:0] w,
                           input logic [15:0] ofs, input logic [AW-1:0] lim);
        bit            ea;
        int            er, rd0, cyc;
        logic [AW-1:0] a0;
        ea  = exp_allow(cpl, iopl, port, w, ofs, lim);
        er  = exp_reads(cpl, iopl, port, w, ofs, lim);
        a0  = byte_addr(ofs, 17'(port));
        @(negedge clk);
        req_cpl = cpl; req_iopl = iopl; req_port = port; req_width = w;
        bitmap_ofs = ofs; seg_limit = lim; req_valid = 1'b1;
        rd0 = rd_total;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8 busy after take", longint'(req_ready), 0);
        // Scramble inputs: results must follow the values taken at acceptance (R8).
        req_cpl = ~cpl; req_iopl = ~iopl; req_port = ~port; req_width = ~w;
        bitmap_ofs = ~ofs; seg_limit = ~lim;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, {tag, " done seen"}, longint'(done), 1);
        check(allow == ea, tag, longint'(allow), longint'(ea));
        check(fault == !ea, "R4 fault opposite of allow", longint'(fault), longint'(!ea));
        check(rd_total - rd0 == er, "R6 read count", longint'(rd_total - rd0), longint'(er));
        check(cyc == er + 2, "R6 latency", longint'(cyc), longint'(er + 2));
        if (er == 1)
            check(last_addr == a0, "R2 read address", longint'(last_addr), longint'(a0));
        if (er == 2) begin
            check(prev_addr == a0, "R6 first address", longint'(prev_addr), longint'(a0));
            check(last_addr == a0 + 1'b1, "R6 second address", longint'(last_addr), longint'(a0 + 1'b1));
        end
        @(negedge clk);
        check(done == 1'b0 && allow == 1'b0 && fault == 1'b0, "R4 pulse ends",
              longint'({done, allow, fault}), 0);
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [AW-1:0] maxlim;
        maxlim = '1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after reset", longint'(req_ready), 1);
        check({done, allow, fault, mem_rd_en} == 4'b0, "R9 quiet after reset",
              longint'({done, allow, fault, mem_rd_en}), 0);

        // R1: privileged, bitmap all ones, even a zero limit.
        pat_mode = 1;
        run_req("R1 equal levels", 2'd0, 2'd0, 16'h0060, 2'b00, 16'h0100, maxlim);
        run_req("R1 more privileged", 2'd2, 2'd3, 16'h03F8, 2'b10, 16'h0100, maxlim);
        run_req("R1 ignores limit", 2'd1, 2'd1, 16'h03FF, 2'b01, 16'h0100, '0);
        // R3: all-ones bitmap denies, all-zero permits.
        run_req("R3 set bit denies", 2'd3, 2'd0, 16'h0060, 2'b00, 16'h0100, maxlim);
        pat_mode = 0;
        run_req("R3 clear bit permits", 2'd3, 2'd1, 16'h0060, 2'b00, 16'h0100, maxlim);
        // R2: single set bit at byte 0x17F bit 5 (port 0x3FD).
        pat_mode = 3; tgt_addr = AW'(17'h017F); tgt_bit = 5;
        run_req("R2 exact bit denies", 2'd3, 2'd2, 16'h03FD, 2'b00, 16'h0100, maxlim);
        run_req("R2 neighbour bit permits", 2'd3, 2'd2, 16'h03FC, 2'b00, 16'h0100, maxlim);
        run_req("R5 two ports reach bit", 2'd3, 2'd2, 16'h03FC, 2'b01, 16'h0100, maxlim);
        // R5: width code 11 covers four ports, bit 7 of 0x17F.
        tgt_bit = 7;
        run_req("R5 code 11 is four ports", 2'd3, 2'd0, 16'h03FC, 2'b11, 16'h0100, maxlim);
        run_req("R5 two ports stop short", 2'd3, 2'd0, 16'h03FC, 2'b01, 16'h0100, maxlim);
        // R6: crossing into byte 0x180, bit 0 (port 0x400).
        tgt_addr = AW'(17'h0180); tgt_bit = 0;
        run_req("R6 cross denies high byte", 2'd3, 2'd0, 16'h03FF, 2'b01, 16'h0100, maxlim);
        run_req("R6 no cross stays low", 2'd3, 2'd0, 16'h03FE, 2'b01, 16'h0100, maxlim);
        run_req("R6 four ports cross", 2'd3, 2'd0, 16'h03FD, 2'b10, 16'h0100, maxlim);
        // R7: limit boundaries with a clear bitmap.
        pat_mode = 0;
        run_req("R7 first byte above limit", 2'd3, 2'd0, 16'h03F8, 2'b00, 16'h0100, AW'(17'h017E));
        run_req("R7 first byte at limit", 2'd3, 2'd0, 16'h03F8, 2'b00, 16'h0100, AW'(17'h017F));
        run_req("R7 second byte above limit", 2'd3, 2'd0, 16'h03FF, 2'b01, 16'h0100, AW'(17'h017F));
        run_req("R7 second byte at limit", 2'd3, 2'd0, 16'h03FF, 2'b01, 16'h0100, AW'(17'h0180));
        // R5: top port spills past 0x1FFF without wrapping.
        run_req("R5 port FFFF no wrap", 2'd3, 2'd0, 16'hFFFF, 2'b10, 16'h0000, maxlim);
        pat_mode = 3; tgt_addr = AW'(17'h02000); tgt_bit = 1;
        run_req("R5 port FFFF reaches 0x2000", 2'd3, 2'd0, 16'hFFFF, 2'b10, 16'h0000, maxlim);

        // Random requests against hashed or single-bit bitmaps.
        for (int i = 0; i < 400; i++) begin
            logic [15:0]   p, o;
            logic [1:0]    w, c, l;
            logic [AW-1:0] a0, lim;
            p = 16'($urandom); o = 16'($urandom); w = 2'($urandom);
            c = 2'($urandom); l = 2'($urandom);
            pat_key  = $urandom;
            pat_mode = ($urandom % 4 == 0) ? 3 : 2;
            a0 = byte_addr(o, 17'(p));
            tgt_addr = a0 + AW'($urandom % 2);
            tgt_bit  = int'($urandom % 8);
            lim = ($urandom % 2 == 1) ? a0 + AW'($urandom % 4) - 1'b1 : maxlim;
            run_req("R2 random", c, l, p, w, o, lim);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule